// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block expands one prefixed vector instruction into a stream of element operations. When a start request arrives while the block is idle, it captures four things: the vector length, a two-bit sub-vector code, a mask-mode bit and a three-bit integer mask code. It also captures the three integer predicate source values, named low, mid and high. From them it builds a per-element enable mask once. It then issues one beat per cycle on a valid/ready handshake. Each beat carries the element index, the sub-element index and the linear register step.

Elements whose predicate bit is clear are never issued, and skipping them costs no cycles. Each enabled element is expanded into one to four consecutive sub-element beats. A single-cycle done pulse closes every request. A request that uses condition-register predication, or a vector length above the supported maximum, ends at once with an illegal-instruction flag beside the done pulse. A zero vector length is a pure no-op. A length of one with all mode fields zero issues exactly one beat, at element 0, sub-element 0, step 0.

Top module: `vec_elem_sequencer`

## Requirements
- R1: When the captured vector length is 0, no beat is issued, whatever the other fields hold. `done_o` pulses in the cycle after start and `illegal_o` stays low.
- R2: A vector length of 1 with sub-vector code 0, mask mode 0 and mask code 0 issues exactly one beat (element 0, sub-element 0, step 0) in the cycle after start. Done follows.
- R3: Sub-vector code 00/01/10/11 gives 1/2/3/4 sub-element beats per enabled element, with sub-element index 0 upward. The step is element*count + sub-element.
- R4: Mask code 000 enables every element below the vector length. Mask code 001 enables only the element whose index equals the low predicate value, so no element is enabled when that value is at or above the vector length.
- R5: Mask codes 010/011 enable element i when bit i of the low value is set/clear. Codes 100/101 apply the same rule to the mid value, and codes 110/111 to the high value.
- R6: When the vector length is nonzero, mask mode 1 or a length above 64 raises `illegal_o` together with `done_o` in the cycle after start. No beat is issued.
- R7: The predicate values are sampled only at start. Changes to them during the loop have no effect on the beats.
- R8: Disabled elements take no cycles. With ready held high, enabled beats appear in consecutive cycles, starting the cycle after start.
- R9: `done_o` is a one-cycle pulse. It comes in the cycle after the last beat handshake, or in the cycle after start when no element is enabled. It never coincides with a valid beat.
- R10: While valid is high and ready is low, the beat fields hold their values.
- R11: A start raised while the block is busy is ignored.
- R12: After reset, valid, done, illegal and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a request; taken only while idle |
| vl_i | input | 7 | Vector length |
| subvl_i | input | 2 | Sub-vector code (count minus one) |
| mask_mode_i | input | 1 | 0 integer predication, 1 unsupported |
| mask_code_i | input | 3 | Integer predicate selector |
| pred_lo_i | input | 64 | Low predicate source value |
| pred_mid_i | input | 64 | Mid predicate source value |
| pred_hi_i | input | 64 | High predicate source value |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| elem_idx_o | output | 6 | Element index of the beat |
| sub_idx_o | output | 2 | Sub-element index of the beat |
| step_o | output | 8 | Linear register step of the beat |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Request rejected, valid with done |
| busy_o | output | 1 | Request in progress |

## Verification
The bench targets the edges of the mask selection:
- a single-element code pointing past the vector length, which a wrong design would answer with a stray beat;
- inverted codes, which a design with the polarity swapped would turn into the complementary element set;
- a full 64-element, four-sub-element loop, which reaches step 255 and exposes an overflowing step width or a lost last element.

It also changes the predicate values mid-loop and raises start while busy. A design that re-sampled its inputs, or accepted a restart, would alter the beat stream. The back-to-back cycle count shows any design that spends idle cycles on masked elements. The zero-length, oversize and condition-register cases show a design that issues beats or flags the wrong request as illegal.

// File: rtl/vec_seq_pkg.sv
// Shared types for the vector element loop sequencer.
// Assumes a single clock domain; holds no logic of its own.
package vec_seq_pkg;

    // Sequencer control states.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vec_pred_mask.sv
// Builds the per-element enable mask from an integer predicate selector.
// Assumes XLEN >= MAX_VL, so every element has a bit in each source value.
module vec_pred_mask #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7
) (
    input  logic [VL_W-1:0]   vl_i,
    input  logic [2:0]        code_i,
    input  logic [XLEN-1:0]   src_lo_i,
    input  logic [XLEN-1:0]   src_mid_i,
    input  logic [XLEN-1:0]   src_hi_i,
    output logic [MAX_VL-1:0] mask_o
);
    logic [XLEN-1:0] chosen;

    // Pick the source value named by the upper two code bits.
    always_comb begin
        unique case (code_i[2:1])
            2'b10:   chosen = src_mid_i;
            2'b11:   chosen = src_hi_i;
            default: chosen = src_lo_i;
        endcase
    end

    for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
        logic raw;
        // Per-element predicate, limited to indices below the vector length.
        always_comb begin
            unique case (code_i)
                3'b000:  raw = 1'b1;
                3'b001:  raw = (src_lo_i == XLEN'(i));
                default: raw = chosen[i] ^ code_i[0];
            endcase
            mask_o[i] = raw && (VL_W'(i) < vl_i);
        end
    end
endmodule

// File: rtl/vec_lowest_set.sv
// Priority encoder: index of the lowest set bit of a vector, plus an any flag.
// Assumes N is a power of two or less; idx is 0 when no bit is set.
module vec_lowest_set #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vec_elem_sequencer.sv
// Top of the sequencer: captures a request, holds the enabled-element mask
// and walks it lowest-first, one beat per handshake, with sub-element expansion.
// Assumes the consumer may stall indefinitely. Predicate sources are read only at start.
module vec_elem_sequencer #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7,
    localparam int IDX_W  = $clog2(MAX_VL),
    localparam int STEP_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [1:0]        subvl_i,
    input  logic              mask_mode_i,
    input  logic [2:0]        mask_code_i,
    input  logic [XLEN-1:0]   pred_lo_i,
    input  logic [XLEN-1:0]   pred_mid_i,
    input  logic [XLEN-1:0]   pred_hi_i,
    input  logic              beat_ready_i,
    output logic              beat_valid_o,
    output logic [IDX_W-1:0]  elem_idx_o,
    output logic [1:0]        sub_idx_o,
    output logic [STEP_W-1:0] step_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              busy_o
);
    import vec_seq_pkg::*;

    seq_state_e        state_q;
    logic [MAX_VL-1:0] rem_q;
    logic [MAX_VL-1:0] new_mask;
    logic [MAX_VL-1:0] rem_next;
    logic [1:0]        nsub_q;
    logic [1:0]        sub_q;
    logic              illegal_q;
    logic              bad_req;
    logic [IDX_W-1:0]  cur_elem;
    logic              cur_any;

    vec_pred_mask #(.XLEN(XLEN), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_mask (
        .vl_i      (vl_i),
        .code_i    (mask_code_i),
        .src_lo_i  (pred_lo_i),
        .src_mid_i (pred_mid_i),
        .src_hi_i  (pred_hi_i),
        .mask_o    (new_mask)
    );

    vec_lowest_set #(.N(MAX_VL), .IDX_W(IDX_W)) u_scan (
        .vec_i (rem_q),
        .idx_o (cur_elem),
        .any_o (cur_any)
    );

    // Reject condition-register mode and oversize lengths; zero length is a no-op.
    always_comb begin
        bad_req = (vl_i != '0) && (mask_mode_i || (vl_i > VL_W'(MAX_VL)));
    end

    // Remaining mask once the current element has finished all its sub-elements.
    always_comb begin
        rem_next = rem_q;
        rem_next[cur_elem] = 1'b0;
    end

    // Request capture, beat advance and completion sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            rem_q     <= '0;
            nsub_q    <= '0;
            sub_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        sub_q  <= '0;
                        nsub_q <= subvl_i;
                        if (bad_req) begin
                            illegal_q <= 1'b1;
                            state_q   <= SEQ_FIN;
                        end else if (new_mask == '0) begin
                            state_q <= SEQ_FIN;
                        end else begin
                            rem_q   <= new_mask;
                            state_q <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (beat_ready_i) begin
                        if (sub_q == nsub_q) begin
                            sub_q <= '0;
                            rem_q <= rem_next;
                            if (rem_next == '0) begin
                                state_q <= SEQ_FIN;
                            end
                        end else begin
                            sub_q <= sub_q + 2'd1;
                        end
                    end
                end
                default: begin
                    illegal_q <= 1'b0;
                    state_q   <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Beat fields and status outputs derived from the state registers.
    always_comb begin
        beat_valid_o = (state_q == SEQ_RUN) && cur_any;
        elem_idx_o   = cur_elem;
        sub_idx_o    = sub_q;
        step_o       = STEP_W'(cur_elem) * STEP_W'({1'b0, nsub_q} + 3'd1) + STEP_W'(sub_q);
        done_o       = (state_q == SEQ_FIN);
        illegal_o    = (state_q == SEQ_FIN) && illegal_q;
        busy_o       = (state_q != SEQ_IDLE);
    end
endmodule

// File: rtl/vec_elem_sequencer_chk.sv
// Property checker for the sequencer, attached through bind.
// Observes ports only; all properties are disabled while reset is asserted.
module vec_elem_sequencer_chk #(
    parameter int IDX_W  = 6,
    parameter int STEP_W = 8,
    parameter int VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [VL_W-1:0]   vl_i,
    input logic [1:0]        subvl_i,
    input logic              mask_mode_i,
    input logic [2:0]        mask_code_i,
    input logic              beat_ready_i,
    input logic              beat_valid_o,
    input logic [IDX_W-1:0]  elem_idx_o,
    input logic [1:0]        sub_idx_o,
    input logic [STEP_W-1:0] step_o,
    input logic              done_o,
    input logic              illegal_o,
    input logic              busy_o
);
    assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(elem_idx_o)
            && $stable(sub_idx_o) && $stable(step_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> !done_o);

    assert_illegal_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o && !beat_valid_o);

    assert_zero_len_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (vl_i == '0) |=> done_o && !illegal_o && !beat_valid_o);

    assert_scalar_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (vl_i == VL_W'(1)) && (subvl_i == 2'b00) && !mask_mode_i
            && (mask_code_i == 3'b000)
        |=> beat_valid_o && (elem_idx_o == '0) && (sub_idx_o == 2'b00) && (step_o == '0));
endmodule

bind vec_elem_sequencer vec_elem_sequencer_chk #(
    .IDX_W(IDX_W), .STEP_W(STEP_W), .VL_W(VL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
    .mask_mode_i(mask_mode_i), .mask_code_i(mask_code_i), .beat_ready_i(beat_ready_i),
    .beat_valid_o(beat_valid_o), .elem_idx_o(elem_idx_o), .sub_idx_o(sub_idx_o),
    .step_o(step_o), .done_o(done_o), .illegal_o(illegal_o), .busy_o(busy_o)
);

// File: tb/test_vec_elem_sequencer.sv
// Self-checking bench: table-driven loop cases, then directed reset, sampling and restart tests.
module test_vec_elem_sequencer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [6:0]  vl;
        logic [1:0]  subvl;
        logic        mode;
        logic [2:0]  code;
        logic [63:0] lo;
        logic [63:0] mid;
        logic [63:0] hi;
        logic        stall;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t TBL [NVEC] = '{
        '{7'd1,  2'd0, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b0},                    // R2
        '{7'd5,  2'd0, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b0},                    // R4 all
        '{7'd4,  2'd3, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b1},                    // R3 R10
        '{7'd8,  2'd0, 1'b0, 3'd1, 64'd5, 64'd0, 64'd0, 1'b0},                    // R4 single
        '{7'd8,  2'd0, 1'b0, 3'd1, 64'd9, 64'd0, 64'd0, 1'b0},                    // R4 past VL
        '{7'd16, 2'd0, 1'b0, 3'd2, 64'h8421, 64'd0, 64'd0, 1'b0},                 // R5
        '{7'd16, 2'd0, 1'b0, 3'd3, 64'hFFF0, 64'd0, 64'd0, 1'b0},                 // R5 inverted
        '{7'd10, 2'd1, 1'b0, 3'd4, 64'd0, 64'h200, 64'd0, 1'b1},                  // R5 mid
        '{7'd10, 2'd0, 1'b0, 3'd5, 64'd0, 64'h3FE, 64'd0, 1'b0},                  // R5 mid inv
        '{7'd64, 2'd2, 1'b0, 3'd6, 64'd0, 64'd0, 64'h8000_0000_0000_0001, 1'b0},  // R5 hi
        '{7'd64, 2'd0, 1'b0, 3'd7, 64'd0, 64'd0, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0},  // R5 hi inv
        '{7'd3,  2'd0, 1'b0, 3'd2, 64'd0, 64'd0, 64'd0, 1'b0},                    // R9 empty
        '{7'd0,  2'd1, 1'b1, 3'd2, 64'hF, 64'd0, 64'd0, 1'b0},                    // R1
        '{7'd65, 2'd0, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b0},                    // R6 oversize
        '{7'd5,  2'd0, 1'b1, 3'd0, 64'd0, 64'd0, 64'd0, 1'b0},                    // R6 cr mode
        '{7'd64, 2'd3, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b1}                     // R3 step 255
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  subvl_i = '0;
    logic        mask_mode_i = 1'b0;
    logic [2:0]  mask_code_i = '0;
    logic [63:0] pred_lo_i = '0;
    logic [63:0] pred_mid_i = '0;
    logic [63:0] pred_hi_i = '0;
    logic        beat_ready_i = 1'b0;
    logic        beat_valid_o;
    logic [5:0]  elem_idx_o;
    logic [1:0]  sub_idx_o;
    logic [7:0]  step_o;
    logic        done_o;
    logic        illegal_o;
    logic        busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_e [512];
    int exp_s [512];
    int exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_elem_sequencer i_vec_elem_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
        .mask_mode_i(mask_mode_i), .mask_code_i(mask_code_i), .pred_lo_i(pred_lo_i),
        .pred_mid_i(pred_mid_i), .pred_hi_i(pred_hi_i), .beat_ready_i(beat_ready_i),
        .beat_valid_o(beat_valid_o), .elem_idx_o(elem_idx_o), .sub_idx_o(sub_idx_o),
        .step_o(step_o), .done_o(done_o), .illegal_o(illegal_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference predicate, written from the requirement text.
    function automatic bit pred(input vec_t v, input int e);
        case (v.code)
            3'd0: return 1'b1;
            3'd1: return v.lo == 64'(e);
            3'd2: return v.lo[e];
            3'd3: return !v.lo[e];
            3'd4: return v.mid[e];
            3'd5: return !v.mid[e];
            3'd6: return v.hi[e];
            default: return !v.hi[e];
        endcase
    endfunction

    // Runs one request and compares every beat; mutate changes sources, restart raises start mid-loop.
    task automatic run_case(input vec_t v, input bit mutate, input bit restart);
        bit exp_ill;
        int k = 0;
        int vcyc = 0;
        bit finished = 1'b0;
        exp_ill = (v.vl != 0) && (v.mode || v.vl > 7'd64);
        exp_n = 0;
        if (!exp_ill) begin
            for (int e = 0; e < int'(v.vl); e++) begin
                if (pred(v, e)) begin
                    for (int s = 0; s <= int'(v.subvl); s++) begin
                        exp_e[exp_n] = e;
                        exp_s[exp_n] = s;
                        exp_n++;
                    end
                end
            end
        end
        @(negedge clk);
        vl_i = v.vl; subvl_i = v.subvl; mask_mode_i = v.mode; mask_code_i = v.code;
        pred_lo_i = v.lo; pred_mid_i = v.mid; pred_hi_i = v.hi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mutate) begin
            pred_lo_i = ~v.lo; pred_mid_i = ~v.mid; pred_hi_i = ~v.hi;   // R7
        end
        for (int cyc = 0; cyc < 2000 && !finished; cyc++) begin
            start_i = restart && (cyc == 1);                              // R11
            if (restart && cyc == 1) begin
                vl_i = 7'd1; mask_code_i = 3'd0;
            end
            if (done_o) begin
                check(k == exp_n, "R9 beats before done", k, exp_n);
                check(illegal_o == exp_ill, "R6 illegal flag", int'(illegal_o), int'(exp_ill));
                check(!beat_valid_o, "R9 no beat with done", int'(beat_valid_o), 0);
                if (!v.stall) check(vcyc == exp_n, "R8 back-to-back cycles", vcyc, exp_n);
                finished = 1'b1;
            end else if (beat_valid_o) begin
                beat_ready_i = v.stall ? (cyc % 3 != 1) : 1'b1;
                vcyc++;
                if (k >= exp_n) begin
                    check(1'b0, "R4/R5 extra beat", int'(elem_idx_o), -1);
                end else if (beat_ready_i) begin
                    check(int'(elem_idx_o) == exp_e[k], "R5 element index", int'(elem_idx_o), exp_e[k]);
                    check(int'(sub_idx_o) == exp_s[k], "R3 sub index", int'(sub_idx_o), exp_s[k]);
                    check(int'(step_o) == exp_e[k] * (int'(v.subvl) + 1) + exp_s[k],
                          "R3 step", int'(step_o), exp_e[k] * (int'(v.subvl) + 1) + exp_s[k]);
                    k++;
                end
            end else begin
                check(1'b0, "R8 idle gap in loop", cyc, -1);
                finished = 1'b1;
            end
            @(negedge clk);
        end
        check(finished, "R9 completion", 0, 1);
        start_i = 1'b0;
        beat_ready_i = 1'b0;
        if (restart) begin
            check(!busy_o && !beat_valid_o, "R11 restart ignored", int'(busy_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!beat_valid_o && !done_o && !illegal_o && !busy_o, "R12 reset state",
              int'({beat_valid_o, done_o, illegal_o, busy_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R12 idle after reset", int'(busy_o), 0);

        for (int i = 0; i < NVEC; i++) run_case(TBL[i], 1'b0, 1'b0);

        // R7: sources flipped after start must not alter the beats
        run_case('{7'd8, 2'd0, 1'b0, 3'd2, 64'hAA, 64'd0, 64'd0, 1'b0}, 1'b1, 1'b0);
        run_case('{7'd12, 2'd1, 1'b0, 3'd5, 64'd0, 64'hF0F, 64'd0, 1'b1}, 1'b1, 1'b0);
        // R11: start while busy is ignored
        run_case('{7'd6, 2'd1, 1'b0, 3'd0, 64'd0, 64'd0, 64'd0, 1'b0}, 1'b0, 1'b1);
        // R4: single-element code selecting the last element
        run_case('{7'd64, 2'd0, 1'b0, 3'd1, 64'd63, 64'd0, 64'd0, 1'b0}, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule